// File: doc/BRIEF.md
# One-time programmable security register

This block holds a small security register of nine 16-bit words behind a word-wide command interface. Four words carry a fixed unique number that is loaded at reset. Four more words start blank for the user to fill. One control word holds a lock bit for each of those two groups. The host writes command codes on the data bus. One code selects the identification read mode, in which reads return the register words by address. Another code returns to the normal read mode. A two-write sequence programs one word.

A program operation can only turn 1s into 0s. The stored word becomes the old value ANDed with the new data. This covers the control word too, so a cleared lock bit can never be set again. A program attempt that fails leaves the storage untouched. It reports the cause in a status byte, which the host reads back after every program attempt. A short busy period, counted in clock cycles, stands in for the programming pulse.

Top module: `otp_secreg`

## Requirements
- R1: After reset the block is in normal read mode, where `rdata` reads 0000h.
- R2: Writing 90h to `wdata[7:0]` enters identification mode. A read from word 80h returns the control word, and its reset value is FFFEh with the default parameters. Words 81h–84h return `FACTORY_ID` bits [15:0] up to [63:48], in that order. Words 85h–88h reset to FFFFh. Any other address reads 0000h. `rdata` is registered and shows the word for the address of the previous cycle.
- R3: Writing FFh returns the block to normal read mode, where reads give 0000h.
- R4: Writing C0h and then writing an address with a data word programs that word to old AND data. After that the mode is status.
- R5: A program address outside 80h–88h changes no word and sets status bit 4 only (status 90h when ready).
- R6: Programming a word in a locked group changes nothing and sets status bits 4 and 1 (status 92h when ready). Control word bit 0 locks words 81h–84h. Bit 1 locks words 85h–88h. A bit value of 0 means locked.
- R7: Programming FFFDh to 80h locks the user words. A later program of FFFFh to 80h cannot set a lock bit again.
- R8: The status byte is on `rdata[7:0]`, with the ready flag in bit 7. Bit 7 reads 0 in the BUSY_CYC+1 reads that follow the confirming write. While the block is busy, writes are ignored. In status mode, reads return the status until 90h or FFh is written.
- R9: Each new program attempt replaces the error bits of the previous one, so a successful program reports exactly 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe: command or program data |
| addr | input | ADDR_W | Word address for reads and program writes |
| wdata | input | DATA_W | Write data; commands use bits [7:0] |
| rdata | output | DATA_W | Registered read data for the current mode |

## Verification
The bench builds the block with BUSY_CYC set to 3. At that value the whole busy window, its last busy cycle and the first ready cycle can be checked read by read, along with a write placed inside the window. It keeps the default factory number 0123_4567_89AB_CDEFh, so each factory word has a distinct value. It also keeps factory lock bit 0 at 0, so the locked-factory error path can be reached without any setup.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  localparam logic [7:0] CMD_IDREAD = 8'h90;
  localparam logic [7:0] CMD_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_PSETUP = 8'hC0;

  typedef enum logic [1:0] {
    M_ARRAY  = 2'd0,
    M_IDENT  = 2'd1,
    M_STATUS = 2'd2,
    M_SETUP  = 2'd3
  } mode_t;
endpackage

// File: rtl/secreg_cmd.sv
module secreg_cmd
  import secreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output mode_t             mode_q,
  output logic              prog_fire,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= M_ARRAY;
      prog_fire <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      prog_fire <= 1'b0;
      if (wr_en && !busy) begin
        if (mode_q == M_SETUP) begin
          prog_fire <= 1'b1;
          prog_addr <= wr_addr;
          prog_data <= wr_data;
          mode_q    <= M_STATUS;
        end else begin
          case (wr_data[7:0])
            CMD_IDREAD: mode_q <= M_IDENT;
            CMD_ARRAY:  mode_q <= M_ARRAY;
            CMD_PSETUP: mode_q <= M_SETUP;
            default:    mode_q <= mode_q;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/secreg_store.sv
module secreg_store #(
  parameter int              ADDR_W        = 8,
  parameter int              DATA_W        = 16,
  parameter int              SEG_WORDS     = 4,
  parameter int              BASE_ADDR     = 'h80,
  parameter logic [4*16-1:0] FACTORY_ID    = 64'h0123_4567_89AB_CDEF,
  parameter logic            FACTORY_LOCK0 = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_fire,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] lock_word,
  output logic              err_range,
  output logic              err_lock
);
  localparam int NWORDS = 1 + 2 * SEG_WORDS;
  localparam int IDX_W  = $clog2(NWORDS);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NWORDS);

  logic [DATA_W-1:0] words     [NWORDS];
  logic [DATA_W-1:0] init_word [NWORDS];

  assign init_word[0] = {{(DATA_W-1){1'b1}}, FACTORY_LOCK0};
  genvar g;
  generate
    for (g = 0; g < SEG_WORDS; g++) begin : g_init
      assign init_word[1 + g]             = FACTORY_ID[g*DATA_W +: DATA_W];
      assign init_word[1 + SEG_WORDS + g] = '1;
    end
  endgenerate

  logic [ADDR_W-1:0] p_off, r_off;
  logic [IDX_W-1:0]  p_idx, r_idx;
  logic              p_in, r_in, p_fac, p_usr;

  always_comb begin
    p_off = prog_addr - BASE;
    r_off = rd_addr - BASE;
    p_idx = p_off[IDX_W-1:0];
    r_idx = r_off[IDX_W-1:0];
    p_in  = (prog_addr >= BASE) && (p_off < LIMIT);
    r_in  = (rd_addr >= BASE) && (r_off < LIMIT);
    p_fac = p_in && (p_off >= ADDR_W'(1)) && (p_off <= ADDR_W'(SEG_WORDS));
    p_usr = p_in && (p_off > ADDR_W'(SEG_WORDS));
    err_range = !p_in;
    err_lock  = (p_fac && !words[0][0]) || (p_usr && !words[0][1]);
    rd_word   = r_in ? words[r_idx] : '0;
    lock_word = words[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) words[i] <= init_word[i];
    end else if (prog_fire && p_in && !err_lock) begin
      words[p_idx] <= words[p_idx] & prog_data;
    end
  end
endmodule

// File: rtl/secreg_busy.sv
module secreg_busy #(
  parameter int BUSY_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic cnt_nz
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= CNT_W'(BUSY_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign cnt_nz = (cnt != '0);
endmodule

// File: rtl/otp_secreg.sv
module otp_secreg
  import secreg_pkg::*;
#(
  parameter int              ADDR_W        = 8,
  parameter int              DATA_W        = 16,
  parameter int              SEG_WORDS     = 4,
  parameter int              BASE_ADDR     = 'h80,
  parameter int              BUSY_CYC      = 8,
  parameter logic [4*16-1:0] FACTORY_ID    = 64'h0123_4567_89AB_CDEF,
  parameter logic            FACTORY_LOCK0 = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  mode_t             mode_q;
  logic              prog_fire, busy, busy_cnt_nz;
  logic [ADDR_W-1:0] prog_addr;
  logic [DATA_W-1:0] prog_data, rd_word, lock_word;
  logic              err_range, err_lock;
  logic              sr_rng, sr_lock;
  logic [7:0]        status;

  assign busy = busy_cnt_nz | prog_fire;

  secreg_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_cmd (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(addr), .wr_data(wdata),
    .busy(busy), .mode_q(mode_q), .prog_fire(prog_fire),
    .prog_addr(prog_addr), .prog_data(prog_data)
  );

  secreg_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_WORDS(SEG_WORDS),
    .BASE_ADDR(BASE_ADDR), .FACTORY_ID(FACTORY_ID), .FACTORY_LOCK0(FACTORY_LOCK0)
  ) i_store (
    .clk(clk), .rst(rst), .prog_fire(prog_fire), .prog_addr(prog_addr),
    .prog_data(prog_data), .rd_addr(addr), .rd_word(rd_word),
    .lock_word(lock_word), .err_range(err_range), .err_lock(err_lock)
  );

  secreg_busy #(.BUSY_CYC(BUSY_CYC)) i_busy (
    .clk(clk), .rst(rst), .load(prog_fire), .cnt_nz(busy_cnt_nz)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_rng  <= 1'b0;
      sr_lock <= 1'b0;
    end else if (prog_fire) begin
      sr_rng  <= err_range | err_lock;
      sr_lock <= err_lock;
    end
  end

  assign status = {!busy, 2'b00, sr_rng, 2'b00, sr_lock, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (mode_q)
        M_ARRAY: rdata <= '0;
        M_IDENT: rdata <= rd_word;
        default: rdata <= {{(DATA_W-8){1'b0}}, status};
      endcase
    end
  end
endmodule

// File: rtl/secreg_chk.sv
module secreg_chk
  import secreg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       prog_fire,
  input logic       busy_cnt_nz,
  input logic       err_range,
  input logic       err_lock,
  input logic       sr_rng,
  input logic       sr_lock,
  input logic [1:0] lock_bits,
  input mode_t      mode_q,
  input logic       rdata7
);
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_bits & ~$past(lock_bits)) == 2'b00);

  assert_no_prog_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy_cnt_nz |-> !prog_fire);

  assert_status_notready_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q == M_STATUS && busy_cnt_nz) |=> !rdata7);

  assert_lockerr_bits_R6: assert property (@(posedge clk) disable iff (rst)
    (prog_fire && err_lock) |=> (sr_rng && sr_lock));

  assert_range_bits_R5: assert property (@(posedge clk) disable iff (rst)
    (prog_fire && err_range) |=> (sr_rng && !sr_lock));
endmodule

bind otp_secreg secreg_chk u_secreg_chk (
  .clk(clk), .rst(rst), .prog_fire(prog_fire), .busy_cnt_nz(busy_cnt_nz),
  .err_range(err_range), .err_lock(err_lock), .sr_rng(sr_rng),
  .sr_lock(sr_lock), .lock_bits(lock_word[1:0]), .mode_q(mode_q),
  .rdata7(rdata[7])
);

// File: tb/test_otp_secreg.sv
module test_otp_secreg;
  localparam int BUSY = 3;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  int checks = 0;
  int bad = 0;

  always #5 clk = ~clk;

  otp_secreg #(.BUSY_CYC(BUSY)) i_otp_secreg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); addr = a;
    @(negedge clk); chk(rdata, exp, req);
  endtask

  task automatic prog(input logic [7:0] a, input logic [15:0] d,
                      input logic [15:0] exp_st, input string req);
    wr(8'h00, 16'h00C0);
    wr(a, d);
    repeat (BUSY + 2) @(negedge clk);
    chk(rdata, exp_st, req);
  endtask

  task automatic t_reset;
    rd(8'h81, 16'h0000, "R1");
  endtask

  task automatic t_ident;
    wr(8'h00, 16'h0090);
    rd(8'h80, 16'hFFFE, "R2");
    rd(8'h81, 16'hCDEF, "R2");
    rd(8'h82, 16'h89AB, "R2");
    rd(8'h84, 16'h0123, "R2");
    rd(8'h88, 16'hFFFF, "R2");
    rd(8'h89, 16'h0000, "R2");
    rd(8'h7F, 16'h0000, "R2");
  endtask

  task automatic t_array;
    wr(8'h00, 16'h00FF);
    rd(8'h82, 16'h0000, "R3");
  endtask

  task automatic t_busy;
    wr(8'h00, 16'h00C0);
    wr(8'h86, 16'hF0F0);
    for (int k = 0; k <= BUSY; k++) begin
      @(negedge clk); chk({15'd0, rdata[7]}, 16'd0, "R8");
    end
    @(negedge clk); chk(rdata, 16'h0080, "R8");
  endtask

  task automatic t_and;
    wr(8'h00, 16'h0090);
    rd(8'h86, 16'hF0F0, "R4");
    prog(8'h86, 16'hFF0F, 16'h0080, "R4");
    wr(8'h00, 16'h0090);
    rd(8'h86, 16'hF000, "R4");
  endtask

  task automatic t_range;
    prog(8'h8A, 16'h0000, 16'h0090, "R5");
    prog(8'h7F, 16'h0000, 16'h0090, "R5");
    wr(8'h00, 16'h0090);
    rd(8'h88, 16'hFFFF, "R5");
  endtask

  task automatic t_fac_lock;
    prog(8'h82, 16'h0000, 16'h0092, "R6");
    prog(8'h87, 16'h00FF, 16'h0080, "R9");
    wr(8'h00, 16'h0090);
    rd(8'h82, 16'h89AB, "R6");
    rd(8'h87, 16'h00FF, "R4");
  endtask

  task automatic t_busy_ignore;
    wr(8'h00, 16'h00C0);
    wr(8'h85, 16'hFFF0);
    wr(8'h00, 16'h0090);
    repeat (BUSY + 2) @(negedge clk);
    chk(rdata, 16'h0080, "R8");
    rd(8'h85, 16'h0080, "R8");
  endtask

  task automatic t_lock;
    prog(8'h80, 16'hFFFD, 16'h0080, "R7");
    wr(8'h00, 16'h0090);
    rd(8'h80, 16'hFFFC, "R7");
    prog(8'h85, 16'h0000, 16'h0092, "R7");
    wr(8'h00, 16'h0090);
    rd(8'h85, 16'hFFF0, "R7");
    prog(8'h80, 16'hFFFF, 16'h0080, "R7");
    wr(8'h00, 16'h0090);
    rd(8'h80, 16'hFFFC, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ident();
    t_array();
    t_busy();
    t_and();
    t_range();
    t_fac_lock();
    t_busy_ignore();
    t_lock();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule